// File: doc/BRIEF.md
# Serial Flash Page Program Sequencer

This block sits on the host side of a single-bit SPI link to a serial NOR flash and writes a run of bytes into one page. A request carries a 24-bit byte address and a length of 1 to 256. The data bytes arrive on a ready/valid byte stream. For each accepted request the sequencer runs three kinds of chip-select frame in order. It sends a one-byte write-enable frame first. Next comes the page-program frame, which carries the opcode, the address and the data bytes. It then sends status-poll frames until the flash reports that its internal write has finished.

Chip select stays low only for whole bytes. It goes back high only after the eighth serial clock of the last byte in a frame, because the flash ignores a program frame that ends mid-byte. A request whose byte run would pass the end of its 256-byte page is rejected at once and the link stays quiet. If the flash still reports busy after a parameterised number of polls, the request ends with a timeout code. In both cases, and on success, the sequencer reports completion with a one-cycle `done` pulse and a result code.

Top module: `spi_page_writer`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `done` is 0 and `req_ready` is 1.
- R2: SPI mode 0 is used. `spi_sck` idles low. Each high and each low phase lasts CLK_DIV clocks. Bytes go out MSB first, `spi_mosi` holds steady while `spi_sck` is high, and `spi_miso` is sampled on the rising edge.
- R3: The first frame of an accepted request holds exactly one byte, 0x06 (write enable).
- R4: The second frame is 0x02, then address bits 23:16, 15:8 and 7:0, then exactly `req_len` data bytes. The data bytes come in stream order and each one is taken by a `wr_valid`/`wr_ready` handshake.
- R5: Every frame holds a whole number of bytes. `spi_cs_n` rises only after the eighth rising `spi_sck` edge of a byte.
- R6: Between frames, `spi_cs_n` stays high for at least CS_GAP clocks.
- R7: Each poll frame is two bytes: 0x05, then one byte read from `spi_miso`. Only bit 0 of the byte read counts, and 1 means busy. When a poll reads 0, the sequencer pulses `done` with `err_code` 0 (success). Otherwise it sends another poll.
- R8: A request is rejected if `req_len` is 0, if `req_len` is above 256, or if address bits 7:0 plus `req_len` exceed 256. A rejected request pulses `done` with `err_code` 1. It drives no frame and takes no stream byte.
- R9: If all POLL_LIMIT polls read busy, `done` pulses with `err_code` 2, and the sequencer is idle and accepts the next request.
- R10: `req_ready` is high only while no request is in progress. It is high again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_addr | input | 24 | Flash byte address of the first data byte |
| req_len | input | 9 | Number of data bytes |
| wr_data | input | 8 | Stream data byte |
| wr_valid | input | 1 | Stream byte offered |
| wr_ready | output | 1 | Stream byte taken when valid |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result at `done`: 0 success, 1 range, 2 timeout |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench targets the edges of the page-range check: a single byte at offset 0xFF, a full page at offset 0, a run that passes the page end by one byte, and lengths of 0 and 257. A wrong bound there would either wrap data into the page start or reject a legal request. It also sets the flash model busy for exactly POLL_LIMIT-1 polls and then for exactly POLL_LIMIT polls. An off-by-one poll counter would then time out a write that succeeded, or wait for one poll too many. The status byte that reports ready has every bit set except bit 0, so a design that tests the whole byte never finishes. Stream gaps come at random times, so a design that leaves a byte out, or that starts a byte before its data is valid, produces a program frame of the wrong length or with the wrong contents.

// File: rtl/spw_pkg.sv
// Package: shared constants and types for the page-program sequencer.
// Assumes a single-bit SPI flash with the usual one-byte opcodes.
package spw_pkg;
    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_PROGRAM   = 8'h02;
    localparam logic [7:0] OP_STATUS    = 8'h05;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_RANGE   = 2'd1,
        RES_TIMEOUT = 2'd2
    } result_t;

    typedef enum logic [1:0] {
        FR_WREN = 2'd0,
        FR_PROG = 2'd1,
        FR_POLL = 2'd2
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/spw_byte_engine.sv
// Module: shifts one byte out and one bit in on a mode-0 SPI link.
// A start pulse while idle loads tx_byte. The serial clock is low for
// CLK_DIV clocks, then high for CLK_DIV clocks, once per bit, MSB first.
// byte_done pulses for one cycle on the falling edge after the eighth bit.
// rx_lsb holds the last bit sampled, which is bit 0 of the byte read.
// Assumes the caller keeps start low while busy.
module spw_byte_engine #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       byte_done,
    output logic       rx_lsb
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;

    // Serial shift sequence: phase timing, bit count, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sck       <= 1'b0;
            div_q     <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            byte_done <= 1'b0;
            rx_lsb    <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    sh_q  <= tx_byte;
                    div_q <= '0;
                    bit_q <= '0;
                end
            end else if (div_q == CW'(CLK_DIV - 1)) begin
                div_q <= '0;
                if (!sck) begin
                    sck    <= 1'b1;
                    rx_lsb <= miso;
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + CW'(1);
            end
        end
    end

    assign mosi = sh_q[7];

    // R5: a new byte is started only when the previous one has finished
    a_r5_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/spw_seq.sv
// Module: frame sequencer. It checks the request range, then runs a
// write-enable frame, a program frame and status-poll frames. It owns chip
// select and gives the byte engine one byte at a time.
// Assumes the engine pulses eng_done once per started byte.
module spw_seq
    import spw_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000,
    parameter int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             done,
    output logic [1:0]       err_code,
    output logic             cs_n,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic             eng_rx_lsb
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int SUM_W = LEN_W + 1;
    localparam int IDX_W = LEN_W + 1;
    localparam int GW    = $clog2(CS_GAP + 1);
    localparam int PW    = $clog2(POLL_LIMIT + 1);

    seq_state_t       state_q;
    frame_t           kind_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic [GW-1:0]    gap_q;
    logic [PW-1:0]    poll_q;
    logic             wip_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic             len_ok;
    logic             is_data;
    logic [SUM_W-1:0] end_sum;

    // Range check: non-zero length, at most one page, no page crossing.
    always_comb begin
        end_sum = SUM_W'(req_addr[OFF_W-1:0]) + SUM_W'(req_len);
        len_ok  = (req_len != '0) && (req_len <= LEN_W'(PAGE_BYTES))
                  && (end_sum <= SUM_W'(PAGE_BYTES));
    end

    // Byte selection for the current frame and position.
    always_comb begin
        is_data  = 1'b0;
        last_idx = '0;
        eng_tx   = 8'h00;
        case (kind_q)
            FR_WREN: eng_tx = OP_WR_ENABLE;
            FR_PROG: begin
                last_idx = IDX_W'(len_q) + IDX_W'(3);
                case (idx_q)
                    IDX_W'(0): eng_tx = OP_PROGRAM;
                    IDX_W'(1): eng_tx = addr_q[23:16];
                    IDX_W'(2): eng_tx = addr_q[15:8];
                    IDX_W'(3): eng_tx = addr_q[7:0];
                    default: begin
                        eng_tx  = wr_data;
                        is_data = 1'b1;
                    end
                endcase
            end
            default: begin
                last_idx = IDX_W'(1);
                eng_tx   = (idx_q == '0) ? OP_STATUS : 8'h00;
            end
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign wr_ready  = (state_q == ST_LOAD) && is_data;
    assign eng_start = (state_q == ST_LOAD) && (!is_data || wr_valid);

    // Frame sequencing, chip select, poll counting and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= FR_WREN;
            idx_q    <= '0;
            gap_q    <= '0;
            poll_q   <= '0;
            wip_q    <= 1'b0;
            addr_q   <= '0;
            len_q    <= '0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            err_code <= RES_OK;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    if (!len_ok) begin
                        done     <= 1'b1;
                        err_code <= RES_RANGE;
                    end else begin
                        addr_q  <= req_addr;
                        len_q   <= req_len;
                        kind_q  <= FR_WREN;
                        idx_q   <= '0;
                        cs_n    <= 1'b0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: if (eng_start) state_q <= ST_SHIFT;
                ST_SHIFT: if (eng_done) begin
                    if (idx_q == last_idx) begin
                        cs_n    <= 1'b1;
                        gap_q   <= '0;
                        state_q <= ST_GAP;
                        if (kind_q == FR_POLL) wip_q <= eng_rx_lsb;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= ST_LOAD;
                    end
                end
                default: begin
                    if (gap_q == GW'(CS_GAP - 1)) begin
                        idx_q <= '0;
                        if (kind_q == FR_WREN) begin
                            kind_q  <= FR_PROG;
                            cs_n    <= 1'b0;
                            state_q <= ST_LOAD;
                        end else if (kind_q == FR_PROG) begin
                            kind_q  <= FR_POLL;
                            poll_q  <= '0;
                            cs_n    <= 1'b0;
                            state_q <= ST_LOAD;
                        end else if (!wip_q) begin
                            done     <= 1'b1;
                            err_code <= RES_OK;
                            state_q  <= ST_IDLE;
                        end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                            done     <= 1'b1;
                            err_code <= RES_TIMEOUT;
                            state_q  <= ST_IDLE;
                        end else begin
                            poll_q  <= poll_q + PW'(1);
                            cs_n    <= 1'b0;
                            state_q <= ST_LOAD;
                        end
                    end else begin
                        gap_q <= gap_q + GW'(1);
                    end
                end
            endcase
        end
    end

    // Checker state: clocks chip select has been high, saturating.
    logic [GW:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_cnt <= (GW+1)'(CS_GAP);
        else if (!cs_n) hi_cnt <= '0;
        else if (hi_cnt < (GW+1)'(CS_GAP)) hi_cnt <= hi_cnt + (GW+1)'(1);
    end

    // R5: chip select rises only right after a byte has completed
    a_r5_cs_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(eng_done));
    // R6: minimum high time before a frame begins
    a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hi_cnt >= (GW+1)'(CS_GAP));
    // R4: stream bytes are taken only inside a selected frame
    a_r4_data_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !cs_n);
    // R10: the sequencer is idle (chip select high) when it offers ready
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);
endmodule

// File: rtl/spi_page_writer.sv
// Module: top of the page-program sequencer. It joins the frame sequencer
// to the mode-0 byte engine. Assumes one flash on the link and that
// CLK_DIV, CS_GAP and POLL_LIMIT are all at least 1.
module spi_page_writer #(
    parameter int CLK_DIV    = 2,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [23:0] req_addr,
    input  logic [8:0]  req_len,
    input  logic [7:0]  wr_data,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic        done,
    output logic [1:0]  err_code,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int PAGE_BYTES = 256;
    localparam int LEN_W      = $clog2(PAGE_BYTES) + 1;

    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_busy;
    logic       eng_done;
    logic       eng_rx_lsb;

    spw_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .CS_GAP     (CS_GAP),
        .POLL_LIMIT (POLL_LIMIT),
        .LEN_W      (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .done       (done),
        .err_code   (err_code),
        .cs_n       (spi_cs_n),
        .eng_start  (eng_start),
        .eng_tx     (eng_tx),
        .eng_done   (eng_done),
        .eng_rx_lsb (eng_rx_lsb)
    );

    spw_byte_engine #(
        .CLK_DIV (CLK_DIV)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .tx_byte   (eng_tx),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .busy      (eng_busy),
        .byte_done (eng_done),
        .rx_lsb    (eng_rx_lsb)
    );

    // R2: the serial clock is low whenever the flash is deselected
    a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R2: the engine runs only inside a selected frame
    a_r2_engine_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !spi_cs_n);
endmodule

// File: tb/spi_page_writer_test.sv
// Bench: flash model on the SPI pins, a random-gap stream source, and
// directed and random page requests checked against bench-computed results.
module spi_page_writer_test;
    localparam int CLK_DIV    = 2;
    localparam int CS_GAP     = 3;
    localparam int POLL_LIMIT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic        done;
    logic [1:0]  err_code;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    spi_page_writer #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .done(done), .err_code(err_code),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    always #4 clk = ~clk;

    int nvec = 0, nfail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Flash model and monitor state
    logic [7:0] fb [0:299];
    logic [7:0] exp_data [0:255];
    int flen = 0, nbits = 0, fidx = 0, busy_left = 0, cur_len = 0;
    logic [23:0] cur_addr = '0;
    logic [7:0] shreg = '0;
    bit armed = 0;
    int cyc = 0, rise_cyc = 0, hi_run = 0;
    int gap_bad = 0, sck_bad = 0, mode_bad = 0;
    logic prev_sck = 1'b0, prev_mosi = 1'b0;
    int send_idx = 0, send_len = 0, consumed = 0;

    function automatic logic [7:0] status_byte();
        return (busy_left > 0) ? 8'h03 : 8'hFE;
    endfunction

    function automatic int exp_result(input logic [23:0] a, input int len, input int busy);
        if (len == 0 || len > 256 || (int'(a[7:0]) + len) > 256) return 1;
        if (busy >= POLL_LIMIT) return 2;
        return 0;
    endfunction

    function automatic int exp_frames(input int res, input int busy);
        if (res == 1) return 0;
        if (res == 2) return 2 + POLL_LIMIT;
        return 3 + busy;
    endfunction

    always @(negedge spi_cs_n) if (armed) begin
        nbits = 0;
        flen = 0;
        if (fidx > 0 && (cyc - rise_cyc) < CS_GAP) gap_bad++;
    end

    always @(posedge spi_sck) if (armed && !spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0) begin
            fb[flen] = shreg;
            flen++;
        end
    end

    always @(negedge spi_sck) if (armed && !spi_cs_n && nbits >= 8 && nbits < 16) begin
        logic [7:0] s;
        s = status_byte();
        spi_miso = s[15 - nbits];
    end

    always @(posedge spi_cs_n) if (armed) begin
        rise_cyc = cyc;
        chk(nbits % 8 == 0, "R5 whole bytes per frame", nbits, (nbits / 8) * 8);
        if (fidx == 0) begin
            chk(flen == 1 && fb[0] == 8'h06, "R3 write-enable frame", int'(fb[0]), 6);
        end else if (fidx == 1) begin
            int bad;
            bad = 0;
            chk(flen == cur_len + 4, "R4 program frame length", flen, cur_len + 4);
            chk(fb[0] == 8'h02 && fb[1] == cur_addr[23:16] && fb[2] == cur_addr[15:8]
                && fb[3] == cur_addr[7:0], "R4 opcode and address", int'(fb[3]), int'(cur_addr[7:0]));
            for (int i = 0; i < cur_len && i + 4 < flen; i++)
                if (fb[i + 4] != exp_data[i]) bad++;
            chk(bad == 0, "R4 data bytes", bad, 0);
        end else begin
            chk(flen == 2 && fb[0] == 8'h05, "R7 poll frame", int'(fb[0]), 5);
            if (busy_left > 0) busy_left--;
        end
        fidx++;
    end

    // Clock-domain monitors sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (armed) begin
            if (spi_sck) hi_run++;
            else if (prev_sck) begin
                if (hi_run != CLK_DIV) sck_bad++;
                hi_run = 0;
            end
            if (spi_sck && prev_sck && spi_mosi != prev_mosi) mode_bad++;
        end
        prev_sck = spi_sck;
        prev_mosi = spi_mosi;
        if (send_idx < send_len) begin
            wr_valid = ($urandom % 4) != 0;
            wr_data = exp_data[send_idx];
        end else begin
            wr_valid = 1'b0;
        end
    end

    always @(posedge clk) if (wr_valid && wr_ready) begin
        consumed++;
        send_idx++;
    end

    task automatic run_req(input logic [23:0] a, input int len, input int busy);
        int res, t;
        res = exp_result(a, len, busy);
        for (int i = 0; i < 256; i++) exp_data[i] = 8'($urandom);
        busy_left = busy; fidx = 0; consumed = 0; send_idx = 0; send_len = len;
        cur_len = len; cur_addr = a;
        gap_bad = 0; sck_bad = 0; mode_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 9'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (res != 1) chk(!req_ready, "R10 busy during request", int'(req_ready), 0);
        t = 0;
        while (!done && t < 60000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 60000, "watchdog", t, 60000);
        chk(int'(err_code) == res, (res == 2) ? "R9 timeout code" :
            (res == 1) ? "R8 range code" : "R7 success code", int'(err_code), res);
        chk(fidx == exp_frames(res, busy), (res == 1) ? "R8 no frames" : "R9/R7 frame count",
            fidx, exp_frames(res, busy));
        chk(consumed == ((res == 1) ? 0 : len), "R8/R4 stream bytes taken", consumed,
            (res == 1) ? 0 : len);
        chk(gap_bad == 0, "R6 chip-select gap", gap_bad, 0);
        chk(sck_bad == 0 && mode_bad == 0, "R2 mode 0 timing", sck_bad + mode_bad, 0);
        send_len = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after done", int'(req_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0 && req_ready == 1'b1,
            "R1 reset state", {spi_cs_n, spi_sck, done, req_ready}, 4'b1001);
        armed = 1;
        run_req(24'h1234FF, 1, 0);
        run_req(24'hABCD00, 256, 1);
        run_req(24'h000010, 241, 0);
        run_req(24'h000000, 0, 0);
        run_req(24'h000000, 257, 0);
        run_req(24'h55AA80, 3, POLL_LIMIT - 1);
        run_req(24'h55AA80, 3, POLL_LIMIT);
        run_req(24'h0F0F00, 2, 0);
        for (int k = 0; k < 12; k++) begin
            logic [23:0] a;
            int len, busy;
            a = 24'($urandom);
            len = 1 + int'($urandom % 64);
            busy = int'($urandom % (POLL_LIMIT + 1));
            run_req(a, len, busy);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule